// File: doc/BRIEF.md
# Dual-Rate Peak-Current PWM Pulse Timer

This block produces the gate-drive timing for a peak-current-mode flyback converter. It is built only from counters. Each switching period starts with the gate driven high. The pulse then ends at whichever comes first of three events: a current-sense trip that arrives after the leading-edge blanking window, the maximum on-time, or a drop of the enable or feedback qualifiers. The comparator decisions reach the block as logic levels that are already synchronous to the system clock.

Two period lengths are available. The normal rate is 65 kHz. The light-load rate is 20 kHz and is used while the light-load flag is high. The rate changes only at a period boundary, so the converter keeps switching under light load and never drops a cycle. The protection logic controls the run-enable input. When that input is low, the output is forced low at once and the period counter is held at its start. All counts are derived from the system clock frequency, so the same code serves any clock rate.

Top module: `pwm_pulse_timer`

## Requirements
- R1: During and after reset, with run_en low, gate_out is 0 and lite_mode is 0.
- R2: With run_en high, fb_low low and light_load low, the gate rises once every CLK_HZ/NORM_HZ cycles (3846 at defaults). The rising edge always falls on the first cycle of a period.
- R3: A period that starts while light_load is high lasts CLK_HZ/LITE_HZ cycles (12500 at defaults), and a pulse is still produced in it.
- R4: lite_mode is 1 for a light-load period and 0 for a normal period. light_load is sampled only at a period start, or while run_en is low. A change in the middle of a period does not alter lite_mode or the length of that period.
- R5: The gate stays high for at most floor(period*DUTY_PCT/100) cycles: 2884 cycles normal and 9375 cycles light at defaults. Without a trip, the pulse lasts exactly that long.
- R6: cs_trip is ignored during the first ceil(BLANK_NS*CLK_HZ/1e9) cycles of each pulse (88 cycles at defaults). A trip sampled at pulse cycle index 87, where the rise is index 0, leaves the gate high.
- R7: cs_trip sampled at a pulse cycle index of 88 or more drives the gate low at the next edge. The gate then stays low for the rest of that period.
- R8: After a trip, the next period starts a new pulse at its normal boundary. For a trip sampled at index 88, the next rise comes 3757 cycles after the fall.
- R9: While fb_low is high, no pulse starts, and a pulse already in progress ends at the next edge. Once fb_low clears, pulses resume at the next period start, with nothing latched.
- R10: If run_en is low at a clock edge, gate_out is 0 after that edge and the period counter is held. The first edge that sees run_en high again starts a new period with the gate high, provided fb_low is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_en | input | 1 | Switching permitted by protection logic |
| cs_trip | input | 1 | Current-sense comparator tripped (peak limit reached) |
| light_load | input | 1 | Feedback below the light-load threshold; selects the slow period |
| fb_low | input | 1 | Feedback too low; suppresses gate pulses while high |
| gate_out | output | 1 | Gate-drive timing output |
| lite_mode | output | 1 | 1 while the current period uses the light-load length |

## Verification
If the period counter picks up a wrong value, the next rising edge of gate_out lands at the wrong cycle, so the error shows within one period. If the blanking count is wrong, a trip at pulse index 87 or 88 has the wrong effect, and the gate edge is off by one cycle right after that trip. If the mode is latched at the wrong time, lite_mode toggles in the middle of a period, or the pulse width leaves its 2884 or 9375 cycle cap. Either fault is visible on the very cycle it happens.

// File: rtl/pwm_timing_pkg.sv
package pwm_timing_pkg;

  typedef enum logic {
    MODE_NORM = 1'b0,
    MODE_LITE = 1'b1
  } sw_mode_e;

  // Whole clock cycles in one switching period.
  function automatic int unsigned per_cycles(input int unsigned clk_hz,
                                             input int unsigned sw_hz);
    return clk_hz / sw_hz;
  endfunction

  // Longest on-time for a period, rounded down.
  function automatic int unsigned on_cycles(input int unsigned per,
                                            input int unsigned pct);
    longint unsigned prod;
    prod = longint'(per) * longint'(pct);
    return int'(prod / 64'd100);
  endfunction

  // Blanking length rounded up so the window is never shorter than asked.
  function automatic int unsigned blank_cycles(input int unsigned clk_hz,
                                               input int unsigned ns);
    longint unsigned prod;
    prod = longint'(clk_hz) * longint'(ns);
    return int'((prod + 64'd999_999_999) / 64'd1_000_000_000);
  endfunction

  function automatic int unsigned max2(input int unsigned a,
                                       input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_s_n = sync_q[1];

endmodule

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr
  import pwm_timing_pkg::*;
#(
  parameter int unsigned NORM_PER = 3846,
  parameter int unsigned LITE_PER = 12500,
  parameter int unsigned NORM_ON  = 2884,
  parameter int unsigned LITE_ON  = 9375,
  parameter int unsigned CW       = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic          light_load,
  output logic [CW-1:0] cnt_o,
  output sw_mode_e      mode_o,
  output logic          pstart_o,
  output logic          on_end_o
);

  localparam logic [CW-1:0] NORM_LAST = CW'(NORM_PER - 1);
  localparam logic [CW-1:0] LITE_LAST = CW'(LITE_PER - 1);
  localparam logic [CW-1:0] NORM_OFF  = CW'(NORM_ON - 1);
  localparam logic [CW-1:0] LITE_OFF  = CW'(LITE_ON - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  sw_mode_e      mode_q, mode_d;
  logic          act_q;
  logic          cnt_en;
  logic          at_last;
  logic [CW-1:0] last_cnt;
  logic [CW-1:0] off_cnt;
  sw_mode_e      mode_in;

  assign mode_in  = light_load ? MODE_LITE : MODE_NORM;
  assign last_cnt = (mode_q == MODE_LITE) ? LITE_LAST : NORM_LAST;
  assign off_cnt  = (mode_q == MODE_LITE) ? LITE_OFF  : NORM_OFF;
  assign at_last  = (cnt_q == last_cnt);

  // A period starts on the first enabled cycle or after the last count.
  assign pstart_o = run_en && (!act_q || at_last);
  assign cnt_en   = run_en && !pstart_o;

  always_comb begin
    cnt_d  = cnt_q;
    mode_d = mode_q;
    if (!run_en) begin
      cnt_d  = '0;
      mode_d = mode_in;
    end else if (pstart_o) begin
      cnt_d  = '0;
      mode_d = mode_in;
    end else if (cnt_en) begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      mode_q <= MODE_NORM;
      act_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      mode_q <= mode_d;
      act_q  <= run_en;
    end
  end

  assign cnt_o    = cnt_q;
  assign mode_o   = mode_q;
  assign on_end_o = (cnt_q == off_cnt);

endmodule

// File: rtl/pwm_blank_win.sv
module pwm_blank_win #(
  parameter int unsigned BLANK = 88
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_q,
  output logic blank_done
);

  generate
    if (BLANK == 0) begin : g_none
      assign blank_done = 1'b1;
    end else begin : g_cnt
      localparam int unsigned BW = $clog2(BLANK + 1);
      localparam logic [BW-1:0] B_END = BW'(BLANK);

      logic [BW-1:0] b_q, b_d;
      logic          b_en;

      assign b_en = gate_q && (b_q != B_END);

      always_comb begin
        b_d = b_q;
        if (!gate_q) begin
          b_d = '0;
        end else if (b_en) begin
          b_d = b_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          b_q <= '0;
        end else begin
          b_q <= b_d;
        end
      end

      assign blank_done = (b_q == B_END);
    end
  endgenerate

endmodule

// File: rtl/pwm_gate_ctl.sv
module pwm_gate_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic pstart,
  input  logic on_end,
  input  logic fb_low,
  input  logic cs_trip,
  input  logic blank_done,
  output logic gate_q
);

  logic gate_d;
  logic trip_hit;
  logic keep_on;

  assign trip_hit = cs_trip && blank_done;
  assign keep_on  = gate_q && !fb_low && !on_end && !trip_hit;

  always_comb begin
    gate_d = 1'b0;
    if (run_en) begin
      if (pstart) begin
        gate_d = !fb_low;
      end else begin
        gate_d = keep_on;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
    end else begin
      gate_q <= gate_d;
    end
  end

endmodule

// File: rtl/pwm_pulse_timer.sv
module pwm_pulse_timer
  import pwm_timing_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 250_000_000,
  parameter int unsigned NORM_HZ  = 65_000,
  parameter int unsigned LITE_HZ  = 20_000,
  parameter int unsigned DUTY_PCT = 75,
  parameter int unsigned BLANK_NS = 350
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic cs_trip,
  input  logic light_load,
  input  logic fb_low,
  output logic gate_out,
  output logic lite_mode
);

  localparam int unsigned NORM_PER  = per_cycles(CLK_HZ, NORM_HZ);
  localparam int unsigned LITE_PER  = per_cycles(CLK_HZ, LITE_HZ);
  localparam int unsigned NORM_ON   = on_cycles(NORM_PER, DUTY_PCT);
  localparam int unsigned LITE_ON   = on_cycles(LITE_PER, DUTY_PCT);
  localparam int unsigned BLANK_CYC = blank_cycles(CLK_HZ, BLANK_NS);
  localparam int unsigned CW        = $clog2(max2(NORM_PER, LITE_PER) + 1);

  logic          rst_s_n;
  logic [CW-1:0] pcnt;
  sw_mode_e      mode;
  logic          pstart;
  logic          on_end;
  logic          blank_done;
  logic          gate_q;

  pwm_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  pwm_period_ctr #(
    .NORM_PER (NORM_PER),
    .LITE_PER (LITE_PER),
    .NORM_ON  (NORM_ON),
    .LITE_ON  (LITE_ON),
    .CW       (CW)
  ) u_per (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .run_en     (run_en),
    .light_load (light_load),
    .cnt_o      (pcnt),
    .mode_o     (mode),
    .pstart_o   (pstart),
    .on_end_o   (on_end)
  );

  pwm_blank_win #(
    .BLANK (BLANK_CYC)
  ) u_blank (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .gate_q     (gate_q),
    .blank_done (blank_done)
  );

  pwm_gate_ctl u_gate (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .run_en     (run_en),
    .pstart     (pstart),
    .on_end     (on_end),
    .fb_low     (fb_low),
    .cs_trip    (cs_trip),
    .blank_done (blank_done),
    .gate_q     (gate_q)
  );

  assign gate_out  = gate_q;
  assign lite_mode = (mode == MODE_LITE);

endmodule

// File: rtl/pwm_pulse_timer_chk.sv
module pwm_pulse_timer_chk #(
  parameter int unsigned NORM_ON = 2884,
  parameter int unsigned LITE_ON = 9375,
  parameter int unsigned BLANK   = 88,
  parameter int unsigned CW      = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run_en,
  input logic          cs_trip,
  input logic          fb_low,
  input logic          gate_out,
  input logic          lite_mode,
  input logic [CW-1:0] pcnt
);

  // Cycles since the current pulse rose; 0 on the rising cycle.
  logic [CW-1:0] hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_len <= '0;
    end else if (gate_out) begin
      hi_len <= hi_len + 1'b1;
    end else begin
      hi_len <= '0;
    end
  end

  p_rise_at_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_out) |-> (pcnt == '0));

  p_mode_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pcnt != '0) |-> $stable(lite_mode));

  p_duty_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gate_out |-> (hi_len < (lite_mode ? CW'(LITE_ON) : CW'(NORM_ON))));

  p_blank_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_out && run_en && !fb_low && (hi_len < CW'(BLANK))) |=> gate_out);

  p_trip_cut_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_out && cs_trip && (hi_len >= CW'(BLANK))) |=> !gate_out);

  p_fb_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fb_low |=> !gate_out);

  p_idle_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !gate_out);

endmodule

bind pwm_pulse_timer pwm_pulse_timer_chk #(
  .NORM_ON (NORM_ON),
  .LITE_ON (LITE_ON),
  .BLANK   (BLANK_CYC),
  .CW      (CW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_s_n),
  .run_en    (run_en),
  .cs_trip   (cs_trip),
  .fb_low    (fb_low),
  .gate_out  (gate_out),
  .lite_mode (lite_mode),
  .pcnt      (pcnt)
);

// File: tb/sim_pwm_pulse_timer.sv
`timescale 1ns/1ps
module sim_pwm_pulse_timer;

  localparam int CLK_HZ = 250_000_000;

  logic clk;
  logic rst_n;
  logic run_en;
  logic cs_trip;
  logic light_load;
  logic fb_low;
  logic gate_out;
  logic lite_mode;

  int nchk;
  int nfail;
  bit cmp_on;
  bit done;

  pwm_pulse_timer u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .cs_trip    (cs_trip),
    .light_load (light_load),
    .fb_low     (fb_low),
    .gate_out   (gate_out),
    .lite_mode  (lite_mode)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int f_period(input bit lite);
    return lite ? CLK_HZ / 20_000 : CLK_HZ / 65_000;
  endfunction

  function automatic int f_maxon(input bit lite);
    return (f_period(lite) * 3) / 4;
  endfunction

  function automatic int f_blank();
    return (350 + 3) / 4;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Behavioural model of the requirements
  bit    m_act, m_mode, m_gate, m_old;
  int    m_cnt, m_hi;
  string m_why;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_cnt = 0; m_mode = 0; m_gate = 0; m_hi = 0; m_why = "R1";
    end else begin
      m_old = m_gate;
      if (!run_en) begin
        m_cnt = 0; m_mode = light_load;
        if (m_gate) m_why = "R10";
        m_gate = 0;
      end else if (!m_act || m_cnt == f_period(m_mode) - 1) begin
        m_cnt = 0; m_mode = light_load; m_gate = !fb_low;
        m_why = fb_low ? "R9" : (m_mode ? "R3" : "R2");
      end else begin
        m_cnt++;
        if (m_gate) begin
          if (fb_low) begin m_gate = 0; m_why = "R9"; end
          else if (cs_trip && m_hi >= f_blank()) begin m_gate = 0; m_why = "R7"; end
          else if (m_hi == f_maxon(m_mode) - 1) begin m_gate = 0; m_why = "R5"; end
          else if (cs_trip) m_why = "R6";
        end
      end
      m_hi  = (m_gate && m_old) ? m_hi + 1 : 0;
      m_act = run_en;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      chk({m_why, " gate"}, int'(gate_out), int'(m_gate));
      chk("R4 mode", int'(lite_mode), int'(m_mode));
    end
  end

  task automatic wait_gate(input logic v, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (gate_out !== v && n < 20000);
  endtask

  initial begin : watchdog
    repeat (200_000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  end

  initial begin : main
    int n1;
    int n2;
    void'($urandom(32'd20240611));
    nchk = 0; nfail = 0; cmp_on = 0; done = 0;
    rst_n = 0; run_en = 0; cs_trip = 0; light_load = 0; fb_low = 0;
    repeat (4) @(negedge clk);
    chk("R1 gate in reset", int'(gate_out), 0);
    chk("R1 mode in reset", int'(lite_mode), 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk("R1 gate after reset", int'(gate_out), 0);
    cmp_on = 1;

    // R2 / R5: normal period and width
    run_en = 1;
    @(negedge clk);
    chk("R10 first pulse on enable", int'(gate_out), 1);
    wait_gate(1'b0, n1);
    chk("R5 normal width", n1, f_maxon(0));
    wait_gate(1'b1, n2);
    wait_gate(1'b0, n1);
    wait_gate(1'b1, n2);
    chk("R2 normal period", n1 + n2, f_period(0));

    // R6 / R7 / R8: trip at blank edge
    repeat (87) @(negedge clk);
    cs_trip = 1;
    @(negedge clk);
    chk("R6 trip inside blanking ignored", int'(gate_out), 1);
    @(negedge clk);
    chk("R7 trip after blanking ends pulse", int'(gate_out), 0);
    cs_trip = 0;
    wait_gate(1'b1, n2);
    chk("R8 next pulse after trip", n2, f_period(0) - 89);

    // R4 / R3: light-load switch mid-period
    repeat (500) @(negedge clk);
    light_load = 1;
    @(negedge clk);
    chk("R4 no mid-period mode change", int'(lite_mode), 0);
    wait_gate(1'b0, n1);
    wait_gate(1'b1, n2);
    chk("R4 mode at boundary", int'(lite_mode), 1);
    wait_gate(1'b0, n1);
    chk("R5 light width", n1, f_maxon(1));
    light_load = 0;
    wait_gate(1'b1, n2);
    chk("R3 light period", n1 + n2, f_period(1));
    chk("R4 back to normal", int'(lite_mode), 0);

    // R9: feedback too low
    repeat (10) @(negedge clk);
    fb_low = 1;
    @(negedge clk);
    chk("R9 pulse cut by fb_low", int'(gate_out), 0);
    n1 = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (gate_out) n1++;
    end
    chk("R9 no pulse while fb_low", n1, 0);
    fb_low = 0;
    wait_gate(1'b1, n2);
    chk("R9 resumes after clear", int'(gate_out), 1);

    // R10: run enable drop
    repeat (100) @(negedge clk);
    run_en = 0;
    @(negedge clk);
    chk("R10 gate drops", int'(gate_out), 0);
    repeat (50) @(negedge clk);
    run_en = 1;
    @(negedge clk);
    chk("R10 restart pulse", int'(gate_out), 1);

    // Random mix
    for (int i = 0; i < 50_000; i++) begin
      @(negedge clk);
      cs_trip = ($urandom_range(0, 99) < 3);
      if ($urandom_range(0, 7999) == 0) light_load = ~light_load;
      if (!fb_low && $urandom_range(0, 5999) == 0) fb_low = 1;
      else if (fb_low && $urandom_range(0, 799) == 0) fb_low = 0;
      if (run_en && $urandom_range(0, 14999) == 0) run_en = 0;
      else if (!run_en && $urandom_range(0, 199) == 0) run_en = 1;
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

endmodule